// File: doc/BRIEF.md
# Double-Press Lamp Brightness Controller

This block runs a lamp from one push-button. The lamp has three settings: dark, lit and bright. From dark, a press lights the lamp and starts measuring how long the lamp has been lit. A second press that arrives within a short window steps the lamp up to bright. A second press that arrives after the window has closed turns the lamp dark again. From bright, any press turns the lamp dark.

Elapsed time is counted in units of an external tick pulse. One tick marks one time unit. The counter saturates, so a very long wait can never wrap around and look like a short one. The press input is expected to be an already debounced, one-cycle pulse. The lamp level comes out of a register, and it is meant to drive a downstream dimmer stage.

Top module: `dblpress_lamp_ctrl`

## Requirements
- R1: While synchronous reset `rst` is high at a clock edge, the controller goes to the dark state after that edge: `state_o` = 0 and `level_o` = 0.
- R2: A press in the dark state (code 0) moves to the lit state (code 1) at the next edge. The elapsed count is set to zero, and a tick in the same cycle is not added to it.
- R3: A press in the lit state moves to the bright state (code 2) when the elapsed count is at most `WINDOW` (default 3) ticks. The boundary value 3 counts as early.
- R4: A press in the lit state moves to the dark state when the elapsed count is greater than `WINDOW` ticks.
- R5: A press in the bright state moves to the dark state.
- R6: In a cycle with no press, the state stays the same, whatever the elapsed count or the tick input.
- R7: The elapsed count saturates and never wraps. With the default 4-bit count, 48 ticks spent in the lit state are still judged late.
- R8: When a press and a tick come in the same cycle, the press is judged on the count before that tick is added. Three earlier ticks plus a coincident tick still give bright.
- R9: `level_o` is registered. It is 0 for dark, 1 for lit and 2 for bright, it always equals `state_o`, and the value 3 never appears on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| press_i | input | 1 | One-cycle button press pulse |
| tick_i | input | 1 | One-cycle time-base pulse, one time unit |
| level_o | output | 2 | Registered lamp level: 0 dark, 1 lit, 2 bright |
| state_o | output | 2 | Current controller state: 0 dark, 1 lit, 2 bright |

## Verification
The main function is tried with second presses that come after 2, 3 and 4 ticks. These separate the early decision from the late one exactly at the window boundary. A press that coincides with a tick is tried both in the dark state and in the lit state. This separates a count judged before the tick from one judged after it, and it shows that the clear beats the increment. A 48-tick wait separates a saturating count from one that wraps back to zero. Ticks with no press, and a reset taken while bright, confirm that nothing but a press or a reset moves the state.

// File: rtl/dblpress_lamp_pkg.sv
package dblpress_lamp_pkg;
   typedef enum logic [1:0] {
      LS_DARK   = 2'd0,
      LS_LIT    = 2'd1,
      LS_BRIGHT = 2'd2
   } lamp_state_t;

   typedef logic [1:0] lamp_level_t;

   function automatic lamp_level_t level_of(input lamp_state_t s);
      case (s)
         LS_LIT:    level_of = 2'd1;
         LS_BRIGHT: level_of = 2'd2;
         default:   level_of = 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/dblpress_elapsed_timer.sv
module dblpress_elapsed_timer #(
   parameter int CNT_W   = 4,
   parameter int WINDOW  = 3,
   parameter bit COMPACT = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic clr_i,
   input  logic tick_i,
   output logic late_o
);
   localparam int FULL_MAX  = (2 ** CNT_W) - 1;
   localparam int SMALL_MAX = WINDOW + 1;
   localparam int SMALL_W   = $clog2(SMALL_MAX + 1);

   generate
      if (WINDOW < 0) begin : g_bad_window
         $error("WINDOW must not be negative");
      end
      if (!COMPACT && (WINDOW >= FULL_MAX)) begin : g_bad_width
         $error("CNT_W too small: count must exceed WINDOW before saturating");
      end

      if (COMPACT) begin : g_compact
         localparam logic [SMALL_W-1:0] TOP = SMALL_W'(SMALL_MAX);
         localparam logic [SMALL_W-1:0] LIM = SMALL_W'(WINDOW);
         logic [SMALL_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || clr_i)
               cnt_q <= '0;
            else if (tick_i && (cnt_q != TOP))
               cnt_q <= cnt_q + 1'b1;
         end
         assign late_o = (cnt_q > LIM);
      end else begin : g_full
         localparam logic [CNT_W-1:0] TOP = '1;
         localparam logic [CNT_W-1:0] LIM = CNT_W'(WINDOW);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (rst || clr_i)
               cnt_q <= '0;
            else if (tick_i && (cnt_q != TOP))
               cnt_q <= cnt_q + 1'b1;
         end
         assign late_o = (cnt_q > LIM);
      end
   endgenerate
endmodule

// File: rtl/dblpress_next_state.sv
module dblpress_next_state
   import dblpress_lamp_pkg::*;
(
   input  lamp_state_t cur_i,
   input  logic        press_i,
   input  logic        late_i,
   output lamp_state_t nxt_o,
   output logic        arm_o
);
   always_comb begin
      nxt_o = cur_i;
      arm_o = 1'b0;
      if (press_i) begin
         case (cur_i)
            LS_DARK: begin
               nxt_o = LS_LIT;
               arm_o = 1'b1;
            end
            LS_LIT:    nxt_o = late_i ? LS_DARK : LS_BRIGHT;
            LS_BRIGHT: nxt_o = LS_DARK;
            default:   nxt_o = LS_DARK;
         endcase
      end
   end
endmodule

// File: rtl/dblpress_level_reg.sv
module dblpress_level_reg
   import dblpress_lamp_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  lamp_state_t nxt_i,
   output lamp_level_t level_o
);
   always_ff @(posedge clk) begin
      if (rst)
         level_o <= 2'd0;
      else
         level_o <= level_of(nxt_i);
   end
endmodule

// File: rtl/dblpress_lamp_ctrl.sv
module dblpress_lamp_ctrl
   import dblpress_lamp_pkg::*;
#(
   parameter int CNT_W   = 4,
   parameter int WINDOW  = 3,
   parameter bit COMPACT = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       press_i,
   input  logic       tick_i,
   output logic [1:0] level_o,
   output logic [1:0] state_o
);
   lamp_state_t state_q, state_d;
   logic        late_w;
   logic        arm_w;

   dblpress_elapsed_timer #(
      .CNT_W  (CNT_W),
      .WINDOW (WINDOW),
      .COMPACT(COMPACT)
   ) timer_i (
      .clk   (clk),
      .rst   (rst),
      .clr_i (arm_w),
      .tick_i(tick_i),
      .late_o(late_w)
   );

   dblpress_next_state nsl_i (
      .cur_i  (state_q),
      .press_i(press_i),
      .late_i (late_w),
      .nxt_o  (state_d),
      .arm_o  (arm_w)
   );

   dblpress_level_reg lvl_i (
      .clk    (clk),
      .rst    (rst),
      .nxt_i  (state_d),
      .level_o(level_o)
   );

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= LS_DARK;
      else
         state_q <= state_d;
   end

   assign state_o = state_q;
endmodule

// File: rtl/dblpress_lamp_ctrl_chk.sv
module dblpress_lamp_ctrl_chk (
   input logic       clk,
   input logic       rst,
   input logic       press_i,
   input logic       tick_i,
   input logic [1:0] state_o,
   input logic [1:0] level_o,
   input logic       late
);
   AST_DARK_TO_LIT: assert property (@(posedge clk) disable iff (rst)
      (press_i && state_o == 2'd0) |=> (state_o == 2'd1)); // R2
   AST_EARLY_BRIGHT: assert property (@(posedge clk) disable iff (rst)
      (press_i && state_o == 2'd1 && !late) |=> (state_o == 2'd2)); // R3
   AST_LATE_DARK: assert property (@(posedge clk) disable iff (rst)
      (press_i && state_o == 2'd1 && late) |=> (state_o == 2'd0)); // R4
   AST_BRIGHT_DARK: assert property (@(posedge clk) disable iff (rst)
      (press_i && state_o == 2'd2) |=> (state_o == 2'd0)); // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !press_i |=> $stable(state_o)); // R6
   AST_LATE_STICKY: assert property (@(posedge clk) disable iff (rst)
      (late && !press_i) |=> late); // R7
   AST_LEVEL_MATCH: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (level_o == state_o)); // R9
   AST_NO_CODE3: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (state_o != 2'd3)); // R9
   logic unused_tick;
   assign unused_tick = tick_i;
endmodule

bind dblpress_lamp_ctrl dblpress_lamp_ctrl_chk chk_i (
   .clk    (clk),
   .rst    (rst),
   .press_i(press_i),
   .tick_i (tick_i),
   .state_o(state_o),
   .level_o(level_o),
   .late   (late_w)
);

// File: tb/dblpress_lamp_ctrl_tb.sv
module dblpress_lamp_ctrl_tb_top;
   localparam int PERIOD = 10;
   localparam int NVEC   = 23;
   // entry = {rst, press, tick, expected state/level[1:0]}
   localparam logic [4:0] VEC [NVEC] = '{
      5'b1_0_0_00, // R1 reset
      5'b0_0_0_00, // R6 idle
      5'b0_0_1_00, // R6 tick only
      5'b0_1_0_01, // R2 dark -> lit
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_1_0_10, // R3 two ticks -> bright
      5'b0_0_1_10, // R6
      5'b0_1_0_00, // R5 bright -> dark
      5'b0_1_0_01, // R2
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_1_0_10, // R3 boundary: three ticks
      5'b0_1_0_00, // R5
      5'b0_1_0_01, // R2
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_0_1_01,
      5'b0_1_0_00, // R4 four ticks -> dark
      5'b0_1_0_01, // R2
      5'b1_0_0_00  // R1 reset from lit
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       press_i = 1'b0;
   logic       tick_i = 1'b0;
   logic [1:0] level_o;
   logic [1:0] state_o;
   int         checks = 0;
   int         fails = 0;

   always #(PERIOD/2) clk = ~clk;

   dblpress_lamp_ctrl dut_i (
      .clk    (clk),
      .rst    (rst),
      .press_i(press_i),
      .tick_i (tick_i),
      .level_o(level_o),
      .state_o(state_o)
   );

   task automatic step(input logic r, input logic p, input logic t,
                       input logic [1:0] exp, input string tag);
      @(negedge clk);
      rst = r; press_i = p; tick_i = t;
      @(posedge clk);
      #(PERIOD/4);
      rst = 1'b0; press_i = 1'b0; tick_i = 1'b0;
      checks++;
      if (state_o !== exp || level_o !== exp) begin
         fails++;
         $display("FAIL %s: state=%0d level=%0d expected=%0d",
                  tag, state_o, level_o, exp);
      end
   endtask

   task automatic ticks(input int n, input logic [1:0] exp, input string tag);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b1, exp, tag);
   endtask

   initial begin
      for (int i = 0; i < NVEC; i++)
         step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0],
              $sformatf("R9 vector %0d", i));

      // R8: press with coincident tick judged on the count before the tick
      step(1'b0, 1'b1, 1'b0, 2'd1, "R2 enter lit");
      ticks(3, 2'd1, "R6 wait");
      step(1'b0, 1'b1, 1'b1, 2'd2, "R8 press+tick at count 3");
      step(1'b0, 1'b1, 1'b0, 2'd0, "R5 bright off");

      // R2: clear wins over a coincident tick
      step(1'b0, 1'b1, 1'b1, 2'd1, "R2 press+tick in dark");
      ticks(3, 2'd1, "R6 wait");
      step(1'b0, 1'b1, 1'b0, 2'd2, "R2 count cleared then 3 ticks");
      step(1'b0, 1'b1, 1'b0, 2'd0, "R5 bright off");

      // R4 + R8: count 4 before coincident tick is late
      step(1'b0, 1'b1, 1'b0, 2'd1, "R2 enter lit");
      ticks(4, 2'd1, "R6 wait");
      step(1'b0, 1'b1, 1'b1, 2'd0, "R4 press+tick at count 4");

      // R7: 48 ticks would wrap a 4-bit count to 0
      step(1'b0, 1'b1, 1'b0, 2'd1, "R2 enter lit");
      ticks(48, 2'd1, "R6 long wait");
      step(1'b0, 1'b1, 1'b0, 2'd0, "R7 saturated count still late");

      // R1: reset from bright
      step(1'b0, 1'b1, 1'b0, 2'd1, "R2 enter lit");
      step(1'b0, 1'b1, 1'b0, 2'd2, "R3 immediate second press");
      step(1'b1, 1'b1, 1'b0, 2'd0, "R1 reset beats press");
      step(1'b0, 1'b0, 1'b0, 2'd0, "R6 idle after reset");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule